// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block sits between eight peripheral request lines and a processor that has one interrupt request pin and one acknowledge pin. Requests are level-sensitive and synchronous. A one-cycle high level on a request line is remembered as pending. A per-line mask filters the pending set, and a selectable priority scheme picks one winner. When the winner qualifies, the block raises the processor interrupt line.

When acknowledge rises, the block drives an 8-bit vector made of a programmable base and the winner's line index. It then moves the winner from pending to in-service. The line stays in service until software issues an end-of-interrupt command through the configuration write port. That port also sets the priority scheme, the mask and the vector base.

The data that leaves the block is a single byte per handshake. Acknowledge paces it, so there is no back-pressure path: the vector is valid for exactly as long as acknowledge is held high. All other pins are plain control and status signals.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the interrupt output is low and the vector output is zero. All lines are masked, so requests raise no interrupt. The scheme is fully nested, the vector base is zero and the rotation pointer is zero.
- R2: Configuration writes are decoded by address. Address 0 sets the scheme from bits 1:0 (00 fully nested, 01 rotating, 10 special mask; 11 behaves as fully nested). Address 1 sets the mask, where bit i = 1 masks line i. Address 2 sets the vector base from bits 7:3. A write to address 3 is an end-of-interrupt command, and its data is ignored.
- R3: A request that is high for one cycle stays pending until it is acknowledged. The interrupt output rises in the cycle after a qualifying unmasked request is latched.
- R4: While acknowledge is high, the vector output equals {base[7:3], line index[2:0]} of the line chosen at the rising edge of acknowledge, and the interrupt output is low. While acknowledge is low, the vector output is zero.
- R5: A rising acknowledge clears the winner's pending bit and sets its in-service bit. The in-service bit takes effect for the following cycles.
- R6: In fully nested mode, line 0 has the highest priority and line 7 the lowest. A request is forwarded only if its priority is strictly higher than every in-service line.
- R7: An end-of-interrupt command clears only the highest-priority in-service bit.
- R8: In rotating mode, an end-of-interrupt that clears line k makes line k+1 (mod 8) the highest priority and line k the lowest.
- R9: In special mask mode, an unmasked pending line may interrupt while a higher-priority line is in service. A line that is already in service is not offered again.
- R10: An acknowledge that arrives while nothing qualifies returns {base, 3'b111} and changes neither the pending nor the in-service state.
- R11: A masked request stays pending, and it interrupts as soon as its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Level-sensitive request lines, line 0 in bit 0 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| intr_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| vec_o | output | 8 | Vector byte, valid while acknowledge is high |

## Verification
The bench builds the block with its default parameters: three index bits, which give eight lines, and an 8-bit vector. The base field is therefore five bits wide. The bench programs the base to 10101, so a corrupted base field shows up in the vector and cannot be mistaken for an index bit. Eight lines let rotating mode move the pointer far enough that its order differs visibly from the fixed order: line 4 beats line 0, and later line 1 beats line 0. With this width the bench also covers nested in-service stacks of two lines, a request at the same priority as the in-service line, and acknowledges that find no qualifying request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    PRIO_NESTED = 2'd0,
    PRIO_ROTATE = 2'd1,
    PRIO_SPMASK = 2'd2,
    PRIO_RSVD   = 2'd3
  } prio_mode_e;

  localparam int CFG_AW = 2;
  localparam logic [CFG_AW-1:0] REG_MODE = 2'd0;
  localparam logic [CFG_AW-1:0] REG_MASK = 2'd1;
  localparam logic [CFG_AW-1:0] REG_BASE = 2'd2;
  localparam logic [CFG_AW-1:0] REG_EOI  = 2'd3;
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int BASE_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [CFG_AW-1:0]    addr_i,
  input  logic [VEC_W-1:0]     wdata_i,
  output prio_mode_e           mode_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [BASE_W-1:0]    base_o,
  output logic                 eoi_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= PRIO_NESTED;
      mask_o <= '1;
      base_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_MODE: mode_o <= prio_mode_e'(wdata_i[1:0]);
        REG_MASK: mask_o <= wdata_i[NUM_LINES-1:0];
        REG_BASE: base_o <= wdata_i[VEC_W-1 -: BASE_W];
        default: ;
      endcase
    end
  end

  assign eoi_o = we_i && (addr_i == REG_EOI);
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int IDX_W = 3
) (
  input  logic [(1<<IDX_W)-1:0] vec_i,
  input  logic [IDX_W-1:0]      top_i,
  output logic                  found_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [IDX_W-1:0]      rank_o
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0] rot;

  for (genvar r = 0; r < N; r++) begin : g_rot
    wire [IDX_W-1:0] src = IDX_W'(r) + top_i;
    assign rot[r] = vec_i[src];
  end

  always_comb begin
    rank_o = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (rot[r]) rank_o = IDX_W'(r);
    end
  end

  assign found_o = |vec_i;
  assign idx_o   = rank_o + top_i;

  // R6: the chosen line is always one that is actually set
  always_comb begin
    if (found_o) a_r6_pick_is_set: assert (vec_i[idx_o]);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int VEC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<IDX_W)-1:0]   irq_i,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [VEC_W-1:0]        cfg_wdata_i,
  output logic                    intr_o,
  input  logic                    inta_i,
  output logic [VEC_W-1:0]        vec_o
);
  localparam int N      = 1 << IDX_W;
  localparam int BASE_W = VEC_W - IDX_W;

  prio_mode_e       mode;
  logic [N-1:0]     mask;
  logic [BASE_W-1:0] base;
  logic             eoi;

  logic [N-1:0]     pend_q, isr_q;
  logic [IDX_W-1:0] top_q, held_idx_q;
  logic             ack_q;

  irqc_cfg_regs #(.NUM_LINES(N), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .mode_o(mode), .mask_o(mask), .base_o(base),
    .eoi_o(eoi)
  );

  logic             spmask, rotate;
  logic [IDX_W-1:0] hi_ptr;
  logic [N-1:0]     cand;

  assign spmask = (mode == PRIO_SPMASK);
  assign rotate = (mode == PRIO_ROTATE);
  assign hi_ptr = rotate ? top_q : '0;
  assign cand   = pend_q & ~mask & (spmask ? ~isr_q : '1);

  logic             c_found, s_found;
  logic [IDX_W-1:0] c_idx, c_rank, s_idx, s_rank;

  irqc_prio_pick #(.IDX_W(IDX_W)) u_cand_pick (
    .vec_i(cand), .top_i(hi_ptr),
    .found_o(c_found), .idx_o(c_idx), .rank_o(c_rank)
  );

  irqc_prio_pick #(.IDX_W(IDX_W)) u_isr_pick (
    .vec_i(isr_q), .top_i(hi_ptr),
    .found_o(s_found), .idx_o(s_idx), .rank_o(s_rank)
  );

  logic             fwd, ack_rise, take;
  logic [IDX_W-1:0] cur_idx;
  logic [N-1:0]     take_oh, eoi_oh;

  assign fwd      = c_found && (spmask || !s_found || (c_rank < s_rank));
  assign ack_rise = inta_i && !ack_q;
  assign take     = ack_rise && fwd;
  assign cur_idx  = ack_q ? held_idx_q : (fwd ? c_idx : '1);
  assign take_oh  = take ? (N'(1) << c_idx) : '0;
  assign eoi_oh   = (eoi && s_found) ? (N'(1) << s_idx) : '0;

  assign intr_o = fwd && !inta_i;
  assign vec_o  = inta_i ? {base, cur_idx} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      isr_q      <= '0;
      top_q      <= '0;
      held_idx_q <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q  <= inta_i;
      pend_q <= (pend_q | irq_i) & ~take_oh;
      isr_q  <= (isr_q & ~eoi_oh) | take_oh;
      if (ack_rise) held_idx_q <= cur_idx;
      if (eoi && s_found && rotate) top_q <= s_idx + 1'b1;
    end
  end

  // R4: vector bus idle when acknowledge is low
  a_r4_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_i |-> (vec_o == '0));

  // R5: an accepted acknowledge leaves the winner in service
  a_r5_take_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> isr_q[$past(c_idx)]);

  // R11: a masked line never wins a handshake
  a_r11_masked_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !mask[c_idx]);

  // R7: end-of-interrupt removes exactly one in-service bit
  a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && s_found && !take) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R8: rotation pointer moves past the line just retired
  a_r8_ptr_follows_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && s_found && rotate) |=> (top_q == IDX_W'($past(s_idx) + 1'b1)));

  // R10: an unqualified acknowledge leaves the in-service set alone
  a_r10_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && !fwd && !eoi) |=> (isr_q == $past(isr_q)));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       intr;
  logic       inta = 1'b0;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .intr_o(intr),
    .inta_i(inta), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq = '0; inta = 1'b0; cfg_we = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq = lines;
    tick();
    irq = '0;
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    inta = 1'b1;
    #1;
    check({tag, " vec"}, 32'(vec), 32'(exp));
    check({tag, " intr low in ack"}, 32'(intr), 32'd0);
    tick();
    check({tag, " vec held"}, 32'(vec), 32'(exp));
    inta = 1'b0;
    #1;
    check({tag, " vec idle"}, 32'(vec), 32'd0);
  endtask

  // {mask, irq, expect_intr, expect_idx}
  localparam logic [19:0] TBL [8] = '{
    {8'h00, 8'h01, 1'b1, 3'd0},
    {8'h00, 8'h80, 1'b1, 3'd7},
    {8'h00, 8'hA4, 1'b1, 3'd2},
    {8'hFE, 8'h03, 1'b1, 3'd0},
    {8'h0F, 8'hF0, 1'b1, 3'd4},
    {8'hFF, 8'hFF, 1'b0, 3'd7},
    {8'h81, 8'h81, 1'b0, 3'd7},
    {8'h10, 8'h18, 1'b1, 3'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, all lines masked
    do_reset();
    check("R1 intr after reset", 32'(intr), 32'd0);
    check("R1 vec after reset", 32'(vec), 32'd0);
    pulse(8'hFF);
    check("R1 masked requests silent", 32'(intr), 32'd0);

    // table walk: R2 R3 R4 R6 R10 with base 10101
    for (int i = 0; i < 8; i++) begin
      logic [19:0] e;
      e = TBL[i];
      do_reset();
      wr(2'd0, 8'h00);
      wr(2'd2, 8'hA8);
      wr(2'd1, e[19:12]);
      pulse(e[11:4]);
      check($sformatf("R3 table %0d intr", i), 32'(intr), 32'(e[3]));
      do_ack($sformatf("R4 table %0d", i), {5'b10101, e[2:0]});
      wr(2'd3, 8'h00);
    end

    // R6 fully nested ordering and in-service blocking
    do_reset();
    wr(2'd1, 8'h00);
    pulse(8'h08);
    check("R3 line3 raises intr", 32'(intr), 32'd1);
    do_ack("R5 ack line3", 8'h03);
    pulse(8'h20);
    check("R6 lower line blocked", 32'(intr), 32'd0);
    pulse(8'h08);
    check("R6 equal line blocked", 32'(intr), 32'd0);
    pulse(8'h02);
    check("R6 higher line forwarded", 32'(intr), 32'd1);
    do_ack("R6 ack line1", 8'h01);
    wr(2'd3, 8'h00);
    check("R7 eoi clears line1 only", 32'(intr), 32'd0);
    wr(2'd3, 8'h00);
    check("R7 eoi clears line3", 32'(intr), 32'd1);
    do_ack("R6 ack repeat line3", 8'h03);
    wr(2'd3, 8'h00);
    do_ack("R6 ack line5", 8'h05);

    // R8 rotating priority
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    pulse(8'h04);
    do_ack("R8 ack line2", 8'h02);
    wr(2'd3, 8'h00);
    pulse(8'h11);
    check("R8 intr after rotate", 32'(intr), 32'd1);
    do_ack("R8 line4 beats line0", 8'h04);
    check("R8 line0 below in-service 4", 32'(intr), 32'd0);
    wr(2'd3, 8'h00);
    do_ack("R8 ack line0", 8'h00);
    wr(2'd3, 8'h00);
    pulse(8'h03);
    do_ack("R8 line1 beats line0", 8'h01);

    // R9 special mask
    do_reset();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    pulse(8'h02);
    do_ack("R9 ack line1", 8'h01);
    pulse(8'h40);
    check("R9 lower line interrupts", 32'(intr), 32'd1);
    do_ack("R9 ack line6", 8'h06);
    pulse(8'h02);
    check("R9 in-service line not offered", 32'(intr), 32'd0);
    wr(2'd3, 8'h00);
    check("R9 line1 offered after eoi", 32'(intr), 32'd1);
    do_ack("R9 ack line1 again", 8'h01);

    // R11 masked request held pending
    do_reset();
    wr(2'd1, 8'h20);
    pulse(8'h20);
    check("R11 masked line silent", 32'(intr), 32'd0);
    wr(2'd1, 8'h00);
    check("R11 unmask raises intr", 32'(intr), 32'd1);
    do_ack("R11 ack line5", 8'h05);

    // R10 spurious acknowledge
    do_reset();
    do_ack("R10 spurious", 8'h07);
    wr(2'd1, 8'h00);
    check("R10 no pending after spurious", 32'(intr), 32'd0);
    pulse(8'h80);
    check("R10 line7 not blocked", 32'(intr), 32'd1);
    do_ack("R10 ack line7", 8'h07);

    // R2 reserved mode acts as nested
    do_reset();
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h00);
    pulse(8'h08);
    do_ack("R2 reserved ack3", 8'h03);
    pulse(8'h40);
    check("R2 reserved mode blocks lower", 32'(intr), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule